// File: doc/BRIEF.md
# Reorder Buffer Issue Scheduler

This block is the instruction window of a single-issue, out-of-order, speculative core that works on renamed physical registers. Decoded instructions are written at the tail of a twelve-slot ring in program order. Each slot holds the tags of two source registers and a ready flag for each. A flag is set either when the instruction is written or when a result tag is broadcast later. Each cycle the block selects at most one slot to send to execution. It retires completed slots from the head, one per cycle, and lets a store reach memory only at that point.

Two selectors work over the same ring, and ages are counted from the head so that wrap-around does not affect ordering. The out-of-order selector takes the oldest ready arithmetic instruction. The in-order selector looks only at the oldest memory or control instruction that has not yet issued. Loads and stores therefore leave in program order, but they may go ahead of older branches that have not resolved. A control-coprocessor instruction acts as a full barrier. When a branch turns out to be mispredicted, every slot younger than it is dropped in one cycle and the tail moves back to the slot just after the branch.

Top module: `rob_sched`

## Requirements
- R1: After reset the ring is empty: occupancy is 0, alloc_ready is 1, and issue_valid and retire_valid are 0.
- R2: alloc_ready is 0 when 12 slots are occupied or flush_valid is 1, and an alloc_valid seen in that cycle is dropped. Otherwise an allocation fills slot alloc_idx, which goes up by one for each allocation and wraps from 11 to 0.
- R3: A source is ready if its alloc ready flag was 1, or if wake_valid carried a matching wake_tag in the allocation cycle or in any later cycle. A wake takes effect for issue in the cycle after it.
- R4: At most one slot issues per cycle, and a slot issues only once. Among kind 0 (arithmetic) slots with both sources ready and no older barrier, the oldest one is the out-of-order candidate, whatever its position relative to older unready slots.
- R5: Kinds 1 (load) and 2 (store) issue in strict program order. Only the oldest unissued slot of kind 1, 2 or 3 can be the in-order candidate, and it must have both sources ready. A ready memory slot may issue while older arithmetic slots are still pending.
- R6: When both selectors have a candidate, the one nearer the head issues.
- R7: A kind 3 (barrier) slot issues only when it is at the head. While a barrier occupies the ring, no slot younger than it issues.
- R8: When the head slot has completed, retire_valid is 1 with retire_idx equal to the head slot, and the head moves on at that edge. An incomplete head stalls retirement.
- R9: store_commit is 1 exactly when the retiring slot is of kind 2.
- R10: A flush with flush_idx removes every slot younger than flush_idx at that edge. The slot flush_idx and older slots survive, and the next allocation uses the slot after flush_idx.
- R11: occupancy always equals the number of live slots and stays between 0 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to write one instruction at the tail |
| alloc_kind | input | 2 | 0 arithmetic, 1 load, 2 store, 3 barrier |
| alloc_src1 | input | 6 | First source physical tag |
| alloc_src1_rdy | input | 1 | First source already available |
| alloc_src2 | input | 6 | Second source physical tag |
| alloc_src2_rdy | input | 1 | Second source already available |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_idx | output | 4 | Slot that an accepted allocation fills |
| wake_valid | input | 1 | Result tag broadcast |
| wake_tag | input | 6 | Tag whose value became available |
| issue_valid | output | 1 | A slot is sent to execution this cycle |
| issue_idx | output | 4 | Slot being issued |
| complete_valid | input | 1 | Execution finished for a slot |
| complete_idx | input | 4 | Slot that finished |
| flush_valid | input | 1 | Mispredicted branch: remove younger slots |
| flush_idx | input | 4 | Slot of the mispredicted branch |
| retire_valid | output | 1 | Head slot retires this cycle |
| retire_idx | output | 4 | Slot retiring |
| store_commit | output | 1 | Retiring slot is a store; memory may be written |
| occupancy | output | 4 | Number of live slots |

## Verification
A wrong ready or issued flag inside the ring shows up at issue_idx in the same cycle the selectors read it. A slot issues too early, twice or never, and a stuck slot later also shows as retire_valid staying low at a head that should have drained. Age arithmetic that is wrong across the wrap point reverses the priority between the two selectors or lets a memory slot pass an older one. This shows on issue_idx only once the head has moved past slot 0, so the stimulus runs long enough to wrap many times. A flush that removes the wrong slots shows in occupancy at the next cycle and in alloc_idx at the next allocation.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KIND_ALU   = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_BAR   = 2'd3
  } kind_e;

  // distance of a slot from the head, in program order
  function automatic int ring_age(int idx, int head, int depth);
    return (idx >= head) ? idx - head : idx + depth - head;
  endfunction

  // slot reached by stepping off places from idx
  function automatic int ring_add(int idx, int off, int depth);
    int s;
    s = idx + off;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
  import rob_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush_valid,
  input  logic [IDX_W-1:0] flush_idx,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);

  logic [IDX_W-1:0] head_step;
  logic [IDX_W-1:0] tail_step;
  logic [IDX_W-1:0] tail_after_flush;
  logic [CNT_W-1:0] count_after_flush;

  always_comb begin
    head_step         = IDX_W'(ring_add(int'(head), 1, DEPTH));
    tail_step         = IDX_W'(ring_add(int'(tail), 1, DEPTH));
    tail_after_flush  = IDX_W'(ring_add(int'(flush_idx), 1, DEPTH));
    count_after_flush = CNT_W'(ring_age(int'(flush_idx), int'(head), DEPTH) + 1
                               - (retire_fire ? 1 : 0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (retire_fire) head <= head_step;
      if (flush_valid) begin
        tail  <= tail_after_flush;
        count <= count_after_flush;
      end else begin
        if (alloc_fire) tail <= tail_step;
        count <= CNT_W'(int'(count) + (alloc_fire ? 1 : 0) - (retire_fire ? 1 : 0));
      end
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  assert_full_blocks_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH) |-> !alloc_fire);

  assert_ptr_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tail) == ring_add(int'(head), int'(count) % DEPTH, DEPTH));

endmodule

// File: rtl/rob_picker.sv
module rob_picker
  import rob_pkg::*;
#(
  parameter int DEPTH    = 12,
  parameter bit IN_ORDER = 1'b0,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] head,
  input  logic [DEPTH-1:0] elig,
  input  logic [DEPTH-1:0] rdy,
  output logic             found,
  output logic [IDX_W-1:0] pick_idx,
  output logic [IDX_W-1:0] pick_age
);

  generate
    if (IN_ORDER) begin : g_inorder
      // the oldest eligible slot is the only one that may go
      always_comb begin
        logic stop;
        int   e;
        stop = 1'b0; found = 1'b0; pick_idx = '0; pick_age = '0;
        for (int a = 0; a < DEPTH; a++) begin
          e = ring_add(int'(head), a, DEPTH);
          if (!stop && elig[e]) begin
            stop     = 1'b1;
            found    = rdy[e];
            pick_idx = IDX_W'(e);
            pick_age = IDX_W'(a);
          end
        end
      end
    end else begin : g_ooo
      // the oldest eligible slot that is also ready
      always_comb begin
        logic stop;
        int   e;
        stop = 1'b0; found = 1'b0; pick_idx = '0; pick_age = '0;
        for (int a = 0; a < DEPTH; a++) begin
          e = ring_add(int'(head), a, DEPTH);
          if (!stop && elig[e] && rdy[e]) begin
            stop     = 1'b1;
            found    = 1'b1;
            pick_idx = IDX_W'(e);
            pick_age = IDX_W'(a);
          end
        end
      end
    end
  endgenerate

  assert_pick_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (elig[pick_idx] && rdy[pick_idx] &&
               int'(pick_age) == ring_age(int'(pick_idx), int'(head), DEPTH)));

endmodule

// File: rtl/rob_sched.sv
module rob_sched
  import rob_pkg::*;
#(
  parameter int DEPTH  = 12,
  parameter int PTAG_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [PTAG_W-1:0] alloc_src1,
  input  logic              alloc_src1_rdy,
  input  logic [PTAG_W-1:0] alloc_src2,
  input  logic              alloc_src2_rdy,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              wake_valid,
  input  logic [PTAG_W-1:0] wake_tag,
  output logic              issue_valid,
  output logic [IDX_W-1:0]  issue_idx,
  input  logic              complete_valid,
  input  logic [IDX_W-1:0]  complete_idx,
  input  logic              flush_valid,
  input  logic [IDX_W-1:0]  flush_idx,
  output logic              retire_valid,
  output logic [IDX_W-1:0]  retire_idx,
  output logic              store_commit,
  output logic [CNT_W-1:0]  occupancy
);

  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             alloc_fire;

  logic [DEPTH-1:0] ent_valid, ent_issued, ent_done, ent_rdy;
  kind_e            ent_kind [DEPTH];

  logic [IDX_W-1:0] flush_age;
  logic [IDX_W-1:0] issue_age;
  int               bar_age;

  logic [DEPTH-1:0] elig_ooo, elig_io, rdy_io;
  logic             ooo_found, io_found;
  logic [IDX_W-1:0] ooo_idx, io_idx, ooo_age, io_age;

  // ---------------- pointers ----------------
  assign alloc_ready = (int'(count) < DEPTH) && !flush_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail;
  assign occupancy   = count;
  assign flush_age   = IDX_W'(ring_age(int'(flush_idx), int'(head), DEPTH));

  rob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .retire_fire (retire_valid),
    .flush_valid (flush_valid),
    .flush_idx   (flush_idx),
    .head        (head),
    .tail        (tail),
    .count       (count)
  );

  // ---------------- slot storage ----------------
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    logic              v, iss, dn, ra, rb;
    kind_e             k;
    logic [PTAG_W-1:0] ta, tb;
    logic              alloc_here, kill_here, retire_here;

    assign alloc_here  = alloc_fire && (tail == SLOT);
    assign retire_here = retire_valid && (head == SLOT);
    assign kill_here   = flush_valid &&
                         (ring_age(g, int'(head), DEPTH) > int'(flush_age));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v <= 1'b0; iss <= 1'b0; dn <= 1'b0; ra <= 1'b0; rb <= 1'b0;
        k <= KIND_ALU; ta <= '0; tb <= '0;
      end else if (alloc_here) begin
        v   <= 1'b1;
        iss <= 1'b0;
        dn  <= 1'b0;
        k   <= kind_e'(alloc_kind);
        ta  <= alloc_src1;
        tb  <= alloc_src2;
        ra  <= alloc_src1_rdy || (wake_valid && wake_tag == alloc_src1);
        rb  <= alloc_src2_rdy || (wake_valid && wake_tag == alloc_src2);
      end else begin
        if (kill_here || retire_here) v <= 1'b0;
        if (issue_valid && issue_idx == SLOT) iss <= 1'b1;
        if (complete_valid && complete_idx == SLOT && v) dn <= 1'b1;
        if (wake_valid && wake_tag == ta) ra <= 1'b1;
        if (wake_valid && wake_tag == tb) rb <= 1'b1;
      end
    end

    assign ent_valid[g]  = v;
    assign ent_issued[g] = iss;
    assign ent_done[g]   = dn;
    assign ent_rdy[g]    = ra && rb;
    assign ent_kind[g]   = k;
  end

  // ---------------- barrier fence and eligibility ----------------
  always_comb begin
    int e;
    bar_age = DEPTH;
    for (int a = DEPTH - 1; a >= 0; a--) begin
      e = ring_add(int'(head), a, DEPTH);
      if (ent_valid[e] && ent_kind[e] == KIND_BAR) bar_age = a;
    end
  end

  always_comb begin
    logic fenced, open_slot;
    for (int e = 0; e < DEPTH; e++) begin
      fenced      = ring_age(e, int'(head), DEPTH) > bar_age;
      open_slot   = ent_valid[e] && !ent_issued[e] && !fenced;
      elig_ooo[e] = open_slot && (ent_kind[e] == KIND_ALU);
      elig_io[e]  = open_slot && (ent_kind[e] != KIND_ALU);
      rdy_io[e]   = ent_rdy[e] && ((ent_kind[e] != KIND_BAR) || (e == int'(head)));
    end
  end

  rob_picker #(.DEPTH(DEPTH), .IN_ORDER(1'b0), .IDX_W(IDX_W)) u_pick_ooo (
    .clk(clk), .rst_n(rst_n), .head(head), .elig(elig_ooo), .rdy(ent_rdy),
    .found(ooo_found), .pick_idx(ooo_idx), .pick_age(ooo_age)
  );

  rob_picker #(.DEPTH(DEPTH), .IN_ORDER(1'b1), .IDX_W(IDX_W)) u_pick_io (
    .clk(clk), .rst_n(rst_n), .head(head), .elig(elig_io), .rdy(rdy_io),
    .found(io_found), .pick_idx(io_idx), .pick_age(io_age)
  );

  // ---------------- single issue slot: older candidate wins ----------------
  always_comb begin
    issue_valid = 1'b0;
    issue_idx   = '0;
    issue_age   = '0;
    if (io_found && (!ooo_found || io_age < ooo_age)) begin
      issue_valid = 1'b1;
      issue_idx   = io_idx;
      issue_age   = io_age;
    end else if (ooo_found) begin
      issue_valid = 1'b1;
      issue_idx   = ooo_idx;
      issue_age   = ooo_age;
    end
  end

  // ---------------- retirement ----------------
  assign retire_valid = ent_valid[head] && ent_done[head];
  assign retire_idx   = head;
  assign store_commit = retire_valid && (ent_kind[head] == KIND_STORE);

  // ---------------- checks ----------------
  logic older_inorder_open;
  always_comb begin
    older_inorder_open = 1'b0;
    for (int e = 0; e < DEPTH; e++)
      if (ent_valid[e] && !ent_issued[e] && ent_kind[e] != KIND_ALU &&
          ring_age(e, int'(head), DEPTH) < int'(issue_age))
        older_inorder_open = 1'b1;
  end

  assert_issue_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (ent_valid[issue_idx] && !ent_issued[issue_idx] && ent_rdy[issue_idx]));

  assert_inorder_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && ent_kind[issue_idx] != KIND_ALU) |-> !older_inorder_open);

  assert_barrier_at_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && ent_kind[issue_idx] == KIND_BAR) |-> (issue_idx == head));

  assert_barrier_fence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (int'(issue_age) <= bar_age));

  assert_retire_issued_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> ent_issued[head]);

  assert_store_only_at_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    store_commit |-> (retire_valid && ent_issued[retire_idx]));

  assert_branch_survives_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !retire_valid) |=> ent_valid[$past(flush_idx)]);

  assert_tail_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) != DEPTH) |-> !ent_valid[tail]);

endmodule

// File: tb/tb_rob_sched.sv
`timescale 1ns/1ps
module tb_rob_sched;

  localparam int DEPTH = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 0, alloc_src1_rdy = 0, alloc_src2_rdy = 0;
  logic [1:0] alloc_kind = 0;
  logic [5:0] alloc_src1 = 0, alloc_src2 = 0, wake_tag = 0;
  logic       wake_valid = 0, complete_valid = 0, flush_valid = 0;
  logic [3:0] complete_idx = 0, flush_idx = 0;
  logic       alloc_ready, issue_valid, retire_valid, store_commit;
  logic [3:0] alloc_idx, issue_idx, retire_idx, occupancy;

  always #4 clk = ~clk;  // 125 MHz

  rob_sched dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_src1(alloc_src1), .alloc_src1_rdy(alloc_src1_rdy),
    .alloc_src2(alloc_src2), .alloc_src2_rdy(alloc_src2_rdy),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .wake_valid(wake_valid), .wake_tag(wake_tag),
    .issue_valid(issue_valid), .issue_idx(issue_idx),
    .complete_valid(complete_valid), .complete_idx(complete_idx),
    .flush_valid(flush_valid), .flush_idx(flush_idx),
    .retire_valid(retire_valid), .retire_idx(retire_idx),
    .store_commit(store_commit), .occupancy(occupancy)
  );

  // reference: program-ordered list, position 0 is the oldest
  typedef struct {
    int idx; int kind; int sa; int sb;
    bit ra; bit rb; bit iss; bit dn;
  } m_ent_t;

  m_ent_t q[$];
  int     mhead = 0;
  int     total = 0, bad = 0;
  bit     after_flush = 0;

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // returns the position chosen for issue, or -1; also tells which pickers had a candidate
  function automatic int ref_issue(output bit two_cands);
    int fence = q.size();
    int o = -1, n = -1;
    for (int i = 0; i < q.size(); i++)
      if (q[i].kind == 3 && fence == q.size()) fence = i;
    for (int i = 0; i < q.size() && i <= fence; i++)
      if (o < 0 && q[i].kind == 0 && !q[i].iss && q[i].ra && q[i].rb) o = i;
    for (int i = 0; i < q.size(); i++)
      if (n < 0 && q[i].kind != 0 && !q[i].iss) n = i;
    if (n > fence) n = -1;
    if (n >= 0 && !(q[n].ra && q[n].rb && (q[n].kind != 3 || n == 0))) n = -1;
    two_cands = (o >= 0 && n >= 0);
    if (o < 0) return n;
    if (n < 0) return o;
    return (n < o) ? n : o;
  endfunction

  task automatic step(int p_alloc, int p_wake, int p_cmp, int p_flush, bit allow_alloc_rdy);
    int fpos = -1, cpos = -1, ipos;
    bit two, exp_ret, fire;
    int cands[$];
    m_ent_t ne;
    @(negedge clk);
    // choose stimulus from the reference state
    alloc_valid    = ($urandom_range(0, 99) < p_alloc);
    alloc_kind     = 2'($urandom_range(0, 9) < 5 ? 0 : $urandom_range(1, 3));
    alloc_src1     = 6'($urandom_range(0, 7));
    alloc_src2     = 6'($urandom_range(0, 7));
    alloc_src1_rdy = allow_alloc_rdy && $urandom_range(0, 1);
    alloc_src2_rdy = allow_alloc_rdy && $urandom_range(0, 1);
    wake_valid     = ($urandom_range(0, 99) < p_wake);
    wake_tag       = 6'($urandom_range(0, 7));
    cands = {};
    for (int i = 0; i < q.size(); i++) if (q[i].iss && !q[i].dn) cands.push_back(i);
    complete_valid = 0;
    if (cands.size() > 0 && $urandom_range(0, 99) < p_cmp) begin
      cpos = cands[$urandom_range(0, cands.size() - 1)];
      complete_valid = 1; complete_idx = 4'(q[cpos].idx);
    end
    cands = {};
    for (int i = 0; i < q.size(); i++) if (q[i].kind == 0) cands.push_back(i);
    flush_valid = 0;
    if (cands.size() > 0 && $urandom_range(0, 99) < p_flush) begin
      fpos = cands[$urandom_range(0, cands.size() - 1)];
      flush_valid = 1; flush_idx = 4'(q[fpos].idx);
    end
    #1;
    // compare outputs against the reference
    chk(alloc_ready == (q.size() < DEPTH && !flush_valid), "R2 alloc_ready",
        int'(alloc_ready), int'(q.size() < DEPTH && !flush_valid));
    if (alloc_ready)
      chk(int'(alloc_idx) == (mhead + q.size()) % DEPTH, "R2 alloc_idx",
          int'(alloc_idx), (mhead + q.size()) % DEPTH);
    ipos = ref_issue(two);
    chk(issue_valid == (ipos >= 0), "R3 issue_valid", int'(issue_valid), int'(ipos >= 0));
    if (ipos >= 0 && issue_valid)
      chk(int'(issue_idx) == q[ipos].idx,
          two ? "R6 issue_idx" : (q[ipos].kind == 0 ? "R4 issue_idx" :
                                 (q[ipos].kind == 3 ? "R7 issue_idx" : "R5 issue_idx")),
          int'(issue_idx), q[ipos].idx);
    exp_ret = (q.size() > 0) && q[0].dn;
    chk(retire_valid == exp_ret, "R8 retire_valid", int'(retire_valid), int'(exp_ret));
    if (exp_ret)
      chk(int'(retire_idx) == q[0].idx, "R8 retire_idx", int'(retire_idx), q[0].idx);
    chk(store_commit == (exp_ret && q[0].kind == 2), "R9 store_commit",
        int'(store_commit), int'(exp_ret && q[0].kind == 2));
    chk(int'(occupancy) == q.size(), after_flush ? "R10 occupancy" : "R11 occupancy",
        int'(occupancy), q.size());
    // advance the reference to the coming edge
    fire = alloc_valid && q.size() < DEPTH && !flush_valid;
    if (ipos >= 0) q[ipos].iss = 1;
    if (cpos >= 0) q[cpos].dn = 1;
    if (wake_valid)
      foreach (q[i]) begin
        if (q[i].sa == int'(wake_tag)) q[i].ra = 1;
        if (q[i].sb == int'(wake_tag)) q[i].rb = 1;
      end
    if (fpos >= 0) q = q[0:fpos];
    after_flush = (fpos >= 0);
    if (exp_ret) begin
      void'(q.pop_front());
      mhead = (mhead + 1) % DEPTH;
    end
    if (fire) begin
      ne.idx  = (mhead + q.size() + (exp_ret ? 1 : 0) - (exp_ret ? 1 : 0)) % DEPTH;
      ne.kind = int'(alloc_kind);
      ne.sa   = int'(alloc_src1);
      ne.sb   = int'(alloc_src2);
      ne.ra   = alloc_src1_rdy || (wake_valid && wake_tag == alloc_src1);
      ne.rb   = alloc_src2_rdy || (wake_valid && wake_tag == alloc_src2);
      ne.iss  = 0;
      ne.dn   = 0;
      q.push_back(ne);
    end
  endtask

  // watchdog: a hang counts as a failure
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state with idle inputs
    chk(occupancy == 0, "R1 occupancy", int'(occupancy), 0);
    chk(alloc_ready == 1, "R1 alloc_ready", int'(alloc_ready), 1);
    chk(issue_valid == 0, "R1 issue_valid", int'(issue_valid), 0);
    chk(retire_valid == 0, "R1 retire_valid", int'(retire_valid), 0);
    // fill to full with nothing ready: R2 stall at twelve
    repeat (20) step(100, 0, 0, 0, 0);
    // drain with wakes only
    repeat (200) step(0, 80, 60, 0, 1);
    // mixed traffic, wraps many times, with flushes
    repeat (6000) step(70, 40, 40, 3, 1);
    // heavy pressure with rare wakes to stress ordering
    repeat (3000) step(90, 15, 30, 2, 0);
    // final drain
    repeat (400) step(0, 90, 80, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule